// File: doc/BRIEF.md
# Radix Page Table Walker

This block resolves one virtual address against a multi-level radix translation tree held in memory. A requester hands it the address to translate, the base of the root directory, the root index width and the total span of the tree in bits. The walker then fetches one 64-bit entry per level through a single-outstanding memory read port. At every level it narrows the remaining span by that level's index width, and it continues until an entry marked as a leaf ends the descent.

On success it returns the leaf entry, the resulting page size in bits and the real address, with the page number taken from the leaf and the in-page offset taken from the request address. A walk can also end in a fault, for two reasons: a fetched entry is not valid, or the tree shape at some level is not one of the supported configurations. The fault is reported with a cause code on the same done pulse that would otherwise carry the result. Permission checks, second-stage translation of entry addresses and result caching are left to surrounding logic.

Top module: `radix_walker`

## Requirements
- R1: The address of the entry fetched at each level is the aligned level base plus 8 times the index, where the index is the request address shifted right by (remaining span minus index width) and masked to index-width bits.
- R2: Base bits below bit position (index width + 3) are cleared before use, both for the root base and for every base taken from a directory entry; a misaligned base never causes a fault.
- R3: A fetched entry with bit 63 (valid) clear ends the walk with fault asserted and fault_cause = 2'b01.
- R4: Each fetched valid entry reduces the remaining span by the current index width; on a leaf, page_bits equals the remaining span after that reduction.
- R5: A valid entry with bit 62 (leaf) clear is a directory: its bits 4:0 give the next index width and its bits 55:8 give the next level base. A valid entry with bit 62 set ends the walk with that entry on leaf_entry.
- R6: Before every fetch the level shape is checked: level 0 needs span 52 and index width 13, levels 1 and 2 need width 9, level 3 accepts width 9 or 5, deeper levels are never valid. A failed check ends the walk with fault_cause = 2'b10 and issues no fetch for that level.
- R7: On success real_addr takes bits 55:12 of the leaf above bit page_bits, the request address below bit page_bits, and zero elsewhere. fault_cause is 2'b00 on success.
- R8: At most one memory read is outstanding; a raised mem_req_valid holds with a stable mem_req_addr until mem_req_ready is seen.
- R9: done is a one-cycle pulse per walk. A request is taken only while req_ready is high (idle); req_valid during a walk has no effect on that walk's result or fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | High while idle; a request is taken when both are high |
| req_addr | input | ADDR_W | Address to translate |
| req_root_base | input | ADDR_W | Root directory base |
| req_root_nls | input | 5 | Root index width in bits |
| req_tree_size | input | 7 | Total span of the tree in bits |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | ADDR_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Fetched entry |
| done | output | 1 | Walk finished (one cycle) |
| fault | output | 1 | Walk ended in a fault |
| fault_cause | output | 2 | 01 no valid entry, 10 unsupported shape, 00 success |
| leaf_entry | output | 64 | Leaf entry of a successful walk |
| page_bits | output | 7 | Page size in bits |
| real_addr | output | ADDR_W | Translated address |

## Verification
Successful walks are run for three page sizes: a four-level walk ending at 12 bits, a three-level walk ending at 21 bits, and a final level with a 5-bit index ending at 16 bits. Together they separate the span arithmetic, the per-level width taken from the directory and the split point of the address merge. Misaligned root and directory bases are compared against the logged fetch addresses to expose missing alignment. Invalid entries, a bad root span, a bad intermediate width and an over-deep tree each produce a distinct fetch count and cause code. A run with memory back-pressure and one with req_valid held during a walk show that handshake timing and stray requests leave the result unchanged.

// File: rtl/rw_pkg.sv
package rw_pkg;
  localparam int ENT_W       = 64;
  localparam int VALID_POS   = 63;
  localparam int LEAF_POS    = 62;
  localparam int NLS_W       = 5;
  localparam int FIELD_MSB   = 55;
  localparam int NLB_LSB     = 8;
  localparam int RPN_LSB     = 12;
  localparam int SIZE_W      = 7;
  localparam int LVL_W       = 3;
  localparam int ENT_BYTES_L = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_WAIT
  } walk_state_e;

  localparam logic [1:0] CAUSE_NONE    = 2'b00;
  localparam logic [1:0] CAUSE_NOENTRY = 2'b01;
  localparam logic [1:0] CAUSE_SHAPE   = 2'b10;

  function automatic logic [ENT_W-1:0] span_mask(input int msb, input int lsb);
    logic [ENT_W-1:0] m;
    for (int b = 0; b < ENT_W; b++) m[b] = (b <= msb) && (b >= lsb);
    return m;
  endfunction

  localparam logic [ENT_W-1:0] NLB_MASK = span_mask(FIELD_MSB, NLB_LSB);
  localparam logic [ENT_W-1:0] RPN_MASK = span_mask(FIELD_MSB, RPN_LSB);
endpackage

// File: rtl/rw_index_gen.sv
module rw_index_gen
  import rw_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] span_i,
  input  logic [NLS_W-1:0]  nls_i,
  output logic [ADDR_W-1:0] entry_addr_o
);
  localparam logic [SIZE_W-1:0] ENT_SH = SIZE_W'(ENT_BYTES_L);

  logic [SIZE_W-1:0] nls_ext;
  logic [SIZE_W-1:0] shamt;
  logic [SIZE_W-1:0] align_sh;
  logic [ADDR_W-1:0] idx_mask;
  logic [ADDR_W-1:0] align_mask;
  logic [ADDR_W-1:0] idx;

  always_comb begin
    nls_ext    = SIZE_W'(nls_i);
    shamt      = (span_i > nls_ext) ? (span_i - nls_ext) : '0;
    align_sh   = nls_ext + ENT_SH;
    idx_mask   = (ADDR_W'(1) << nls_ext) - ADDR_W'(1);
    align_mask = (ADDR_W'(1) << align_sh) - ADDR_W'(1);
    idx        = (addr_i >> shamt) & idx_mask;
    entry_addr_o = (base_i & ~align_mask) + (idx << ENT_SH);
  end
endmodule

// File: rtl/rw_shape_check.sv
module rw_shape_check
  import rw_pkg::*;
#(
  parameter int ROOT_SPAN  = 52,
  parameter int ROOT_NLS   = 13,
  parameter int MID_NLS    = 9,
  parameter int LAST_NLS_A = 9,
  parameter int LAST_NLS_B = 5,
  parameter int NUM_LEVELS = 4
) (
  input  logic [LVL_W-1:0]  level_i,
  input  logic [SIZE_W-1:0] span_i,
  input  logic [NLS_W-1:0]  nls_i,
  output logic              ok_o
);
  localparam int LAST_LVL = NUM_LEVELS - 1;

  logic [NUM_LEVELS-1:0] lvl_ok;

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
    if (g == 0) begin : g_root
      assign lvl_ok[g] = (level_i == LVL_W'(g)) &&
                         (span_i == SIZE_W'(ROOT_SPAN)) &&
                         (nls_i == NLS_W'(ROOT_NLS));
    end else if (g == LAST_LVL) begin : g_last
      assign lvl_ok[g] = (level_i == LVL_W'(g)) &&
                         ((nls_i == NLS_W'(LAST_NLS_A)) ||
                          (nls_i == NLS_W'(LAST_NLS_B)));
    end else begin : g_mid
      assign lvl_ok[g] = (level_i == LVL_W'(g)) &&
                         (nls_i == NLS_W'(MID_NLS));
    end
  end

  assign ok_o = |lvl_ok;
endmodule

// File: rtl/rw_leaf_merge.sv
module rw_leaf_merge
  import rw_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] page_num_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] psize_i,
  output logic [ADDR_W-1:0] real_addr_o
);
  logic [ADDR_W-1:0] low_mask;

  always_comb begin
    if (psize_i >= SIZE_W'(ADDR_W)) low_mask = '1;
    else low_mask = (ADDR_W'(1) << psize_i) - ADDR_W'(1);
    real_addr_o = (page_num_i & ~low_mask) | (addr_i & low_mask);
  end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import rw_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_root_base,
  input  logic [NLS_W-1:0]  req_root_nls,
  input  logic [SIZE_W-1:0] req_tree_size,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_cause,
  output logic [ENT_W-1:0]  leaf_entry,
  output logic [SIZE_W-1:0] page_bits,
  output logic [ADDR_W-1:0] real_addr
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // walk context
  walk_state_e       state_q, state_d;
  logic [LVL_W-1:0]  level_q, level_d;
  logic [SIZE_W-1:0] span_q, span_d;
  logic [NLS_W-1:0]  nls_q, nls_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] vaddr_q, vaddr_d;
  logic              ctx_en;

  // result registers
  logic              fin;
  logic              fin_fault;
  logic [1:0]        fin_cause;
  logic [ENT_W-1:0]  fin_leaf;
  logic [SIZE_W-1:0] fin_psize;
  logic [ADDR_W-1:0] fin_ra;
  logic              done_q;
  logic              fault_q;
  logic [1:0]        cause_q;
  logic [ENT_W-1:0]  leaf_q;
  logic [SIZE_W-1:0] psize_q;
  logic [ADDR_W-1:0] ra_q;

  // shared datapath
  logic              idle;
  logic [ADDR_W-1:0] ig_base;
  logic [ADDR_W-1:0] ig_addr;
  logic [SIZE_W-1:0] ig_span;
  logic [NLS_W-1:0]  ig_nls;
  logic [ADDR_W-1:0] ig_entry_addr;
  logic [SIZE_W-1:0] span_after;
  logic              shape_ok;
  logic [ADDR_W-1:0] page_num;
  logic [ADDR_W-1:0] merged_ra;
  logic              ent_valid;
  logic              ent_leaf;

  assign idle       = (state_q == ST_IDLE);
  assign span_after = span_q - SIZE_W'(nls_q);
  assign ent_valid  = mem_rsp_data[VALID_POS];
  assign ent_leaf   = mem_rsp_data[LEAF_POS];
  assign page_num   = ADDR_W'(mem_rsp_data & RPN_MASK);

  always_comb begin
    if (idle) begin
      ig_base = req_root_base;
      ig_addr = req_addr;
      ig_span = req_tree_size;
      ig_nls  = req_root_nls;
    end else begin
      ig_base = ADDR_W'(mem_rsp_data & NLB_MASK);
      ig_addr = vaddr_q;
      ig_span = span_after;
      ig_nls  = mem_rsp_data[NLS_W-1:0];
    end
  end

  rw_index_gen #(.ADDR_W(ADDR_W)) u_index (
    .base_i       (ig_base),
    .addr_i       (ig_addr),
    .span_i       (ig_span),
    .nls_i        (ig_nls),
    .entry_addr_o (ig_entry_addr)
  );

  rw_shape_check u_shape (
    .level_i (level_q),
    .span_i  (span_q),
    .nls_i   (nls_q),
    .ok_o    (shape_ok)
  );

  rw_leaf_merge #(.ADDR_W(ADDR_W)) u_merge (
    .page_num_i  (page_num),
    .addr_i      (vaddr_q),
    .psize_i     (span_after),
    .real_addr_o (merged_ra)
  );

  // next-state logic
  always_comb begin
    state_d       = state_q;
    level_d       = level_q;
    span_d        = span_q;
    nls_d         = nls_q;
    ptr_d         = ptr_q;
    vaddr_d       = vaddr_q;
    ctx_en        = 1'b0;
    fin           = 1'b0;
    fin_fault     = 1'b0;
    fin_cause     = CAUSE_NONE;
    fin_leaf      = '0;
    fin_psize     = '0;
    fin_ra        = '0;
    mem_req_valid = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ctx_en  = 1'b1;
          level_d = '0;
          span_d  = req_tree_size;
          nls_d   = req_root_nls;
          vaddr_d = req_addr;
          ptr_d   = ig_entry_addr;
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (shape_ok) begin
          state_d = ST_FETCH;
        end else begin
          fin       = 1'b1;
          fin_fault = 1'b1;
          fin_cause = CAUSE_SHAPE;
          state_d   = ST_IDLE;
        end
      end
      ST_FETCH: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (!ent_valid) begin
            fin       = 1'b1;
            fin_fault = 1'b1;
            fin_cause = CAUSE_NOENTRY;
            state_d   = ST_IDLE;
          end else if (ent_leaf) begin
            fin       = 1'b1;
            fin_leaf  = mem_rsp_data;
            fin_psize = span_after;
            fin_ra    = merged_ra;
            state_d   = ST_IDLE;
          end else begin
            ctx_en  = 1'b1;
            level_d = level_q + LVL_W'(1);
            span_d  = span_after;
            nls_d   = mem_rsp_data[NLS_W-1:0];
            ptr_d   = ig_entry_addr;
            state_d = ST_CHECK;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      level_q <= '0;
      span_q  <= '0;
      nls_q   <= '0;
      ptr_q   <= '0;
      vaddr_q <= '0;
    end else if (ctx_en) begin
      level_q <= level_d;
      span_q  <= span_d;
      nls_q   <= nls_d;
      ptr_q   <= ptr_d;
      vaddr_q <= vaddr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) done_q <= 1'b0;
    else             done_q <= fin;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
      leaf_q  <= '0;
      psize_q <= '0;
      ra_q    <= '0;
    end else if (fin) begin
      fault_q <= fin_fault;
      cause_q <= fin_cause;
      leaf_q  <= fin_leaf;
      psize_q <= fin_psize;
      ra_q    <= fin_ra;
    end
  end

  assign req_ready    = idle;
  assign mem_req_addr = ptr_q;
  assign done         = done_q;
  assign fault        = fault_q;
  assign fault_cause  = cause_q;
  assign leaf_entry   = leaf_q;
  assign page_bits    = psize_q;
  assign real_addr    = ra_q;
endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk
  import rw_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              done,
  input logic              fault,
  input logic [1:0]        fault_cause,
  input logic [SIZE_W-1:0] page_bits,
  input logic [ADDR_W-1:0] real_addr
);
  logic              pending_q;
  logic [ADDR_W-1:0] addr_lat_q;
  logic [ADDR_W-1:0] low_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= 1'b0;
    else if (mem_req_valid && mem_req_ready) pending_q <= 1'b1;
    else if (mem_rsp_valid) pending_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_lat_q <= '0;
    else if (req_valid && req_ready) addr_lat_q <= req_addr;
  end

  always_comb begin
    if (page_bits >= SIZE_W'(ADDR_W)) low_mask = '1;
    else low_mask = (ADDR_W'(1) << page_bits) - ADDR_W'(1);
  end

  // R8: request held stable until accepted
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R8: no second read while one is in flight
  p_single_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |-> !mem_req_valid);

  // R9: done lasts a single cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: walker is idle when it reports, and idle means no fetch
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);

  // R3 / R6: a fault carries exactly one cause bit
  p_fault_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> ($countones(fault_cause) == 1));

  // R7: success has no cause and keeps the in-page offset
  p_ok_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (fault_cause == 2'b00));
  p_offset_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (((real_addr ^ addr_lat_q) & low_mask) == '0));
endmodule

bind radix_walker radix_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_addr      (req_addr),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .done          (done),
  .fault         (fault),
  .fault_cause   (fault_cause),
  .page_bits     (page_bits),
  .real_addr     (real_addr)
);

// File: tb/radix_walker_tb_top.sv
module radix_walker_tb_top;
  localparam logic [63:0] V  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] L  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] NB = 64'h00FF_FFFF_FFFF_FF00;
  localparam logic [63:0] RP = 64'h00FF_FFFF_FFFF_F000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_addr;
  logic [63:0] req_root_base;
  logic [4:0]  req_root_nls;
  logic [6:0]  req_tree_size;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        done;
  logic        fault;
  logic [1:0]  fault_cause;
  logic [63:0] leaf_entry;
  logic [6:0]  page_bits;
  logic [63:0] real_addr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int fcnt   = 0;
  logic        stall_en = 1'b0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] flog [0:255];

  // captured result of the last walk
  logic        r_ok;
  logic        r_fault;
  logic [1:0]  r_cause;
  logic [63:0] r_leaf;
  logic [6:0]  r_bits;
  logic [63:0] r_ra;
  int          r_nf;
  int          r_f0;

  always #5 clk = ~clk;

  radix_walker dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_root_base(req_root_base), .req_root_nls(req_root_nls),
    .req_tree_size(req_tree_size),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .fault_cause(fault_cause),
    .leaf_entry(leaf_entry), .page_bits(page_bits), .real_addr(real_addr)
  );

  assign mem_req_ready = !stall_en || (cyc % 4 == 3);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'd0;
      flog[fcnt[7:0]] <= mem_req_addr;
      fcnt <= fcnt + 1;
    end
  end

  task automatic summary_and_end();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    while (cyc < 100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, act=%0d cycles exp<100000", cyc);
    summary_and_end();
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ent_at(input logic [63:0] base, input logic [63:0] a,
                                         input int span, input int nls);
    logic [63:0] am = (64'd1 << (nls + 3)) - 64'd1;
    logic [63:0] ix = (a >> (span - nls)) & ((64'd1 << nls) - 64'd1);
    return (base & ~am) + (ix << 3);
  endfunction

  function automatic logic [63:0] dir_e(input logic [63:0] nlb, input logic [4:0] nls);
    return V | (nlb & NB) | {59'd0, nls};
  endfunction

  function automatic logic [63:0] leaf_e(input logic [63:0] rpn);
    return V | L | (rpn & RP);
  endfunction

  function automatic logic [63:0] merge(input logic [63:0] rpn, input logic [63:0] a, input int ps);
    logic [63:0] m = (64'd1 << ps) - 64'd1;
    return ((rpn & RP) & ~m) | (a & m);
  endfunction

  task automatic walk(input logic [63:0] a, input logic [63:0] base, input logic [4:0] nls,
                      input logic [6:0] sz, input int hold);
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_root_base = base;
    req_root_nls = nls; req_tree_size = sz;
    r_f0 = fcnt;
    @(negedge clk);
    req_addr = ~a; req_root_base = 64'h0000_0000_00F0_0000;
    for (int h = 0; h < hold; h++) @(negedge clk);
    req_valid = 1'b0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    r_ok = done;
    r_fault = fault; r_cause = fault_cause; r_leaf = leaf_entry;
    r_bits = page_bits; r_ra = real_addr;
    r_nf = fcnt - r_f0;
    chk(r_ok, "R9 walk completes with done", {63'd0, done}, 64'd1);
  endtask

  // four-level chain, 13/9/9/9 widths, leaf at level 3
  task automatic build4(input logic [63:0] a, input logic [63:0] root, input logic [63:0] rpn);
    mem.delete();
    mem[ent_at(root, a, 52, 13)]         = dir_e(64'h20_0000, 5'd9);
    mem[ent_at(64'h20_0000, a, 39, 9)]   = dir_e(64'h30_0000, 5'd9);
    mem[ent_at(64'h30_0000, a, 30, 9)]   = dir_e(64'h40_0000, 5'd9);
    mem[ent_at(64'h40_0000, a, 21, 9)]   = leaf_e(rpn);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R9 idle after reset", {63'd0, req_ready}, 64'd1);
    chk(done == 1'b0 && mem_req_valid == 1'b0, "R9 no done or fetch after reset",
        {62'd0, done, mem_req_valid}, 64'd0);
  endtask

  task automatic t_four_level();
    logic [63:0] a   = 64'h0000_1234_5678_9ABC;
    logic [63:0] rpn = 64'h0000_00AB_CDE0_1000;
    build4(a, 64'h1_0000, rpn);
    walk(a, 64'h1_0000, 5'd13, 7'd52, 0);
    chk(r_nf == 4, "R5 four fetches for four-level walk", r_nf, 4);
    chk(flog[r_f0[7:0]] == ent_at(64'h1_0000, a, 52, 13), "R1 root entry address",
        flog[r_f0[7:0]], ent_at(64'h1_0000, a, 52, 13));
    chk(flog[8'(r_f0 + 3)] == ent_at(64'h40_0000, a, 21, 9), "R1 level-3 entry address",
        flog[8'(r_f0 + 3)], ent_at(64'h40_0000, a, 21, 9));
    chk(!r_fault && r_cause == 2'b00, "R7 success has cause 00", {62'd0, r_cause}, 0);
    chk(r_bits == 7'd12, "R4 page bits after 13+9+9+9", r_bits, 12);
    chk(r_leaf == leaf_e(rpn), "R5 leaf entry returned", r_leaf, leaf_e(rpn));
    chk(r_ra == merge(rpn, a, 12), "R7 real address 4K page", r_ra, merge(rpn, a, 12));
    @(negedge clk);
    chk(done == 1'b0, "R9 done lasts one cycle", {63'd0, done}, 0);
  endtask

  task automatic t_two_meg();
    logic [63:0] a   = 64'h0000_0F0E_0D0C_0B0A;
    logic [63:0] rpn = 64'h0000_0012_3460_0000;
    mem.delete();
    mem[ent_at(64'h1_0000, a, 52, 13)]       = dir_e(64'h20_0000, 5'd9);
    mem[ent_at(64'h20_0000, a, 39, 9)]       = dir_e(64'h30_0000, 5'd9);
    mem[ent_at(64'h30_0000, a, 30, 9)]       = leaf_e(rpn | 64'h1_F000);
    walk(a, 64'h1_0000, 5'd13, 7'd52, 0);
    chk(r_nf == 3 && !r_fault, "R5 leaf at level 2 ends after 3 fetches", r_nf, 3);
    chk(r_bits == 7'd21, "R4 page bits 21 for level-2 leaf", r_bits, 21);
    chk(r_ra == merge(rpn | 64'h1_F000, a, 21), "R7 real address 2M page",
        r_ra, merge(rpn | 64'h1_F000, a, 21));
  endtask

  task automatic t_64k();
    logic [63:0] a   = 64'h0000_0ABC_DEF0_1357;
    logic [63:0] rpn = 64'h0000_0077_8888_0000;
    mem.delete();
    mem[ent_at(64'h1_0000, a, 52, 13)]       = dir_e(64'h20_0000, 5'd9);
    mem[ent_at(64'h20_0000, a, 39, 9)]       = dir_e(64'h30_0000, 5'd9);
    mem[ent_at(64'h30_0000, a, 30, 9)]       = dir_e(64'h40_0100, 5'd5);
    mem[ent_at(64'h40_0100, a, 21, 5)]       = leaf_e(rpn);
    walk(a, 64'h1_0000, 5'd13, 7'd52, 0);
    chk(flog[8'(r_f0 + 3)] == ent_at(64'h40_0100, a, 21, 5), "R1 5-bit index at level 3",
        flog[8'(r_f0 + 3)], ent_at(64'h40_0100, a, 21, 5));
    chk(!r_fault && r_bits == 7'd16, "R6 width 5 accepted at level 3, 16-bit page", r_bits, 16);
    chk(r_ra == merge(rpn, a, 16), "R7 real address 64K page", r_ra, merge(rpn, a, 16));
  endtask

  task automatic t_misaligned();
    logic [63:0] a   = 64'h0000_0555_AAAA_5555;
    logic [63:0] rpn = 64'h0000_00C0_0000_0000;
    mem.delete();
    mem[ent_at(64'h1_0000, a, 52, 13)]  = dir_e(64'h20_0800, 5'd9);
    mem[ent_at(64'h20_0000, a, 39, 9)]  = leaf_e(rpn);
    walk(a, 64'h1_1238, 5'd13, 7'd52, 0);
    chk(flog[r_f0[7:0]] == ent_at(64'h1_0000, a, 52, 13), "R2 root base low bits cleared",
        flog[r_f0[7:0]], ent_at(64'h1_0000, a, 52, 13));
    chk(flog[8'(r_f0 + 1)] == ent_at(64'h20_0000, a, 39, 9), "R2 directory base low bits cleared",
        flog[8'(r_f0 + 1)], ent_at(64'h20_0000, a, 39, 9));
    chk(!r_fault && r_bits == 7'd30, "R2 misalignment raises no fault", {62'd0, r_cause}, 0);
  endtask

  task automatic t_invalid();
    logic [63:0] a = 64'h0000_0123_4567_89AB;
    mem.delete();
    mem[ent_at(64'h1_0000, a, 52, 13)] = dir_e(64'h20_0000, 5'd9);
    mem[ent_at(64'h20_0000, a, 39, 9)] = 64'h7FFF_FFFF_FFFF_FFFF;
    walk(a, 64'h1_0000, 5'd13, 7'd52, 0);
    chk(r_fault && r_cause == 2'b01, "R3 invalid entry gives cause 01", {62'd0, r_cause}, 1);
    chk(r_nf == 2, "R3 walk stops at invalid entry", r_nf, 2);
  endtask

  task automatic t_bad_root();
    walk(64'h0000_0000_1234_0000, 64'h1_0000, 5'd13, 7'd48, 0);
    chk(r_fault && r_cause == 2'b10, "R6 root span 48 rejected", {62'd0, r_cause}, 2);
    chk(r_nf == 0, "R6 no fetch on bad root shape", r_nf, 0);
  endtask

  task automatic t_bad_mid();
    logic [63:0] a = 64'h0000_0321_0000_1000;
    mem.delete();
    mem[ent_at(64'h1_0000, a, 52, 13)] = dir_e(64'h20_0000, 5'd7);
    walk(a, 64'h1_0000, 5'd13, 7'd52, 0);
    chk(r_fault && r_cause == 2'b10 && r_nf == 1, "R6 width 7 at level 1 rejected",
        {r_nf[31:0], 30'd0, r_cause}, {32'd1, 32'd2});
  endtask

  task automatic t_too_deep();
    logic [63:0] a = 64'h0000_0999_8888_7777;
    mem.delete();
    mem[ent_at(64'h1_0000, a, 52, 13)] = dir_e(64'h20_0000, 5'd9);
    mem[ent_at(64'h20_0000, a, 39, 9)] = dir_e(64'h30_0000, 5'd9);
    mem[ent_at(64'h30_0000, a, 30, 9)] = dir_e(64'h40_0000, 5'd9);
    mem[ent_at(64'h40_0000, a, 21, 9)] = dir_e(64'h50_0000, 5'd9);
    walk(a, 64'h1_0000, 5'd13, 7'd52, 0);
    chk(r_fault && r_cause == 2'b10, "R6 level 4 is never valid", {62'd0, r_cause}, 2);
    chk(r_nf == 4, "R6 no fetch for level 4", r_nf, 4);
  endtask

  task automatic t_busy_ignore();
    logic [63:0] a   = 64'h0000_0246_8ACE_0246;
    logic [63:0] rpn = 64'h0000_0033_4455_6000;
    build4(a, 64'h1_0000, rpn);
    walk(a, 64'h1_0000, 5'd13, 7'd52, 3);
    chk(r_ra == merge(rpn, a, 12) && !r_fault, "R9 request during walk ignored",
        r_ra, merge(rpn, a, 12));
    chk(r_nf == 4, "R9 stray request adds no fetch", r_nf, 4);
    for (int k = 0; k < 4; k++) @(negedge clk);
    chk(req_ready && (fcnt - r_f0) == 4, "R9 stays idle once request dropped",
        fcnt - r_f0, 4);
  endtask

  task automatic t_backpressure();
    logic [63:0] a   = 64'h0000_0135_7913_5791;
    logic [63:0] rpn = 64'h0000_0066_0000_3000;
    build4(a, 64'h8_0000, rpn);
    stall_en = 1'b1;
    walk(a, 64'h8_0000, 5'd13, 7'd52, 0);
    stall_en = 1'b0;
    chk(r_nf == 4 && r_ra == merge(rpn, a, 12), "R8 result unchanged under back-pressure",
        r_ra, merge(rpn, a, 12));
    chk(flog[8'(r_f0 + 2)] == ent_at(64'h30_0000, a, 30, 9), "R8 stalled address kept",
        flog[8'(r_f0 + 2)], ent_at(64'h30_0000, a, 30, 9));
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_root_base = '0;
    req_root_nls = '0; req_tree_size = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_four_level();
    t_two_meg();
    t_64k();
    t_misaligned();
    t_invalid();
    t_bad_root();
    t_bad_mid();
    t_too_deep();
    t_busy_ignore();
    t_backpressure();
    repeat (4) @(negedge clk);
    summary_and_end();
  end
endmodule